// File: doc/BRIEF.md
# GPIO Port Input Debounce Filter

This block cleans up the eight input pins of one GPIO port before they reach edge or level detection. Each pin is first brought into the clock domain through a short flop chain. A pin whose filter is switched on reports a new level only after its synchronized input has held that level for a programmed number of millisecond ticks. A pin whose filter is switched off passes its synchronized level straight through.

All eight pins share one 8-bit duration register, counted in millisecond ticks supplied from outside. Each pin keeps its own stability counter and its own on/off bit. The on/off bits can be written as a whole word, or through a masked word that changes only selected pins. Both registers can be read back, so software can save and restore them. Two uses are typical: slow mechanical switches on some pins, and fast signals on the other pins of the same port.

Top module: `gpio_port_debounce`

## Requirements
- R1: While `rst` is high, the enable register and the duration register clear to 0 and every `pin_filt` bit loads its synchronized input, so `pin_filt` equals a `pin_raw` that was held steady during reset, with no spurious transition when reset is released.
- R2: A pin whose enable bit is 0 shows on `pin_filt` the value `pin_raw` had three clock edges earlier: two synchronizer stages, then the output register.
- R3: A masked enable write uses `en_mask_wdata[8+n]` as the select for pin n and `en_mask_wdata[n]` as its new value. Pins whose select bit is 0 keep their enable bit.
- R4: A direct enable write replaces all eight enable bits, and a duration write replaces the duration register. Both show on the read-back ports on the next cycle. When a direct write and a masked write arrive in the same cycle, the masked pins take the masked value and the other pins take the direct value.
- R5: For an enabled pin with duration N > 0, `pin_filt` takes a new level on the clock after the N-th tick during which the synchronized input has differed from `pin_filt` without interruption.
- R6: If the synchronized input returns to the reported level before N ticks have passed, the pin's progress is discarded. A later change must again last N full ticks.
- R7: A duration of 0 makes every enabled pin behave like a disabled one, as in R2.
- R8: Clearing one pin's enable bit while that pin is counting makes that pin follow its input on the next cycle. The progress and reported level of the other pins are not affected.
- R9: Without `ms_tick`, an enabled pin with a non-zero duration never changes its reported level, however long its input stays different.
- R10: If the duration is lowered below a pin's progress, that pin takes the new level at its next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 8 | Asynchronous pin levels |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| en_we | input | 1 | Direct enable write strobe |
| en_wdata | input | 8 | Direct enable write value |
| en_mask_we | input | 1 | Masked enable write strobe |
| en_mask_wdata | input | 16 | Upper byte selects pins, lower byte gives their values |
| dbc_cnt_we | input | 1 | Duration write strobe |
| dbc_cnt_wdata | input | 8 | Duration in ticks |
| en_rdata | output | 8 | Enable register read-back |
| dbc_cnt_rdata | output | 8 | Duration register read-back |
| pin_filt | output | 8 | Filtered pin levels |

## Verification
A stability counter that does not clear after a bounce, or that counts cycles instead of ticks, shows up at `pin_filt` as a level change on the wrong tick. A reference model that is compared on every clock catches that within one tick. A corrupted enable bit or duration shows up at the read-back ports on the cycle after the write. It also changes when a pin's output follows its input, which shows up within three clocks. The stimulus is arranged so that each of these errors produces an early transition, a late transition or a missed transition.

// File: rtl/gpd_pkg.sv
package gpd_pkg;
    localparam int GPD_PINS  = 8;
    localparam int GPD_CNT_W = 8;
    localparam int GPD_SYNC  = 2;

    typedef enum logic [1:0] {
        GPD_FOLLOW = 2'd0,
        GPD_IDLE   = 2'd1,
        GPD_STEP   = 2'd2,
        GPD_COMMIT = 2'd3
    } gpd_act_e;

    function automatic gpd_act_e gpd_decide(
        input logic bypass,
        input logic same,
        input logic tick,
        input logic reached
    );
        if (bypass)
            return GPD_FOLLOW;
        else if (same || !tick)
            return GPD_IDLE;
        else if (reached)
            return GPD_COMMIT;
        else
            return GPD_STEP;
    endfunction
endpackage

// File: rtl/gpd_sync.sv
module gpd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= d;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) chain[s] <= chain[s-1];
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpd_cfg.sv
module gpd_cfg #(
    parameter int PINS  = 8,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_we,
    input  logic [PINS-1:0]   dir_d,
    input  logic              msk_we,
    input  logic [2*PINS-1:0] msk_d,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_d,
    output logic [PINS-1:0]   en_q,
    output logic [CNT_W-1:0]  cnt_q
);
    logic [PINS-1:0] sel, val, base, en_nx;

    always_comb begin
        sel   = msk_we ? msk_d[2*PINS-1:PINS] : '0;
        val   = msk_d[PINS-1:0];
        base  = dir_we ? dir_d : en_q;
        en_nx = (base & ~sel) | (val & sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            cnt_q <= '0;
        end else begin
            en_q <= en_nx;
            if (cnt_we) cnt_q <= cnt_d;
        end
    end

    a_r3_unselected_kept: assert property (@(posedge clk) disable iff (rst)
        (msk_we && !dir_we) |=> ((en_q & ~$past(msk_d[2*PINS-1:PINS]))
                                 == ($past(en_q) & ~$past(msk_d[2*PINS-1:PINS]))));
    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> $stable(cnt_q));
    a_r4_en_hold: assert property (@(posedge clk) disable iff (rst)
        (!dir_we && !msk_we) |=> $stable(en_q));
endmodule

// File: rtl/gpd_pin.sv
module gpd_pin
    import gpd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    input  logic             tick,
    output logic             level
);
    logic [CNT_W-1:0] run;
    logic             bypass, reached;
    gpd_act_e         act;

    always_comb begin
        bypass  = !en || (limit == '0);
        reached = ({1'b0, run} + 1'b1) >= {1'b0, limit};
        act     = gpd_decide(bypass, sync_in == level, tick, reached);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= sync_in;
            run   <= '0;
        end else begin
            case (act)
                GPD_FOLLOW: begin level <= sync_in; run <= '0; end
                GPD_COMMIT: begin level <= sync_in; run <= '0; end
                GPD_STEP:   run <= run + 1'b1;
                default:    if (sync_in == level) run <= '0;
            endcase
        end
    end

    a_r7_bypass_follows: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (level == $past(sync_in)));
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tick) |=> $stable(level));
    a_r6_match_clears: assert property (@(posedge clk) disable iff (rst)
        (!bypass && sync_in == level) |=> (run == '0));
    a_r5_early_hold: assert property (@(posedge clk) disable iff (rst)
        (!bypass && tick && !reached) |=> $stable(level));
endmodule

// File: rtl/gpio_port_debounce.sv
module gpio_port_debounce
    import gpd_pkg::*;
#(
    parameter int PINS        = GPD_PINS,
    parameter int CNT_W       = GPD_CNT_W,
    parameter int SYNC_STAGES = GPD_SYNC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_raw,
    input  logic              ms_tick,
    input  logic              en_we,
    input  logic [PINS-1:0]   en_wdata,
    input  logic              en_mask_we,
    input  logic [2*PINS-1:0] en_mask_wdata,
    input  logic              dbc_cnt_we,
    input  logic [CNT_W-1:0]  dbc_cnt_wdata,
    output logic [PINS-1:0]   en_rdata,
    output logic [CNT_W-1:0]  dbc_cnt_rdata,
    output logic [PINS-1:0]   pin_filt
);
    logic [PINS-1:0] synced;

    gpd_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_raw),
        .q   (synced)
    );

    gpd_cfg #(.PINS(PINS), .CNT_W(CNT_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .dir_we (en_we),
        .dir_d  (en_wdata),
        .msk_we (en_mask_we),
        .msk_d  (en_mask_wdata),
        .cnt_we (dbc_cnt_we),
        .cnt_d  (dbc_cnt_wdata),
        .en_q   (en_rdata),
        .cnt_q  (dbc_cnt_rdata)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        gpd_pin #(.CNT_W(CNT_W)) u_pin (
            .clk     (clk),
            .rst     (rst),
            .sync_in (synced[p]),
            .en      (en_rdata[p]),
            .limit   (dbc_cnt_rdata),
            .tick    (ms_tick),
            .level   (pin_filt[p])
        );
    end

    a_r8_disabled_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pin_filt & ~$past(en_rdata)) == ($past(synced) & ~$past(en_rdata))));
endmodule

// File: tb/gpio_port_debounce_test.sv
module gpio_port_debounce_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  pin_raw;
    logic        ms_tick;
    logic        en_we;
    logic [7:0]  en_wdata;
    logic        en_mask_we;
    logic [15:0] en_mask_wdata;
    logic        dbc_cnt_we;
    logic [7:0]  dbc_cnt_wdata;
    logic [7:0]  en_rdata;
    logic [7:0]  dbc_cnt_rdata;
    logic [7:0]  pin_filt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    // reference state
    logic [7:0] m_s1, m_s2, m_filt, m_en, m_cnt;
    int         m_run [8];

    always #4 clk = ~clk;

    gpio_port_debounce uut (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .ms_tick(ms_tick),
        .en_we(en_we), .en_wdata(en_wdata),
        .en_mask_we(en_mask_we), .en_mask_wdata(en_mask_wdata),
        .dbc_cnt_we(dbc_cnt_we), .dbc_cnt_wdata(dbc_cnt_wdata),
        .en_rdata(en_rdata), .dbc_cnt_rdata(dbc_cnt_rdata), .pin_filt(pin_filt)
    );

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_filt = m_s2;
            m_en   = '0;
            m_cnt  = '0;
            for (int p = 0; p < 8; p++) m_run[p] = 0;
        end else begin
            for (int p = 0; p < 8; p++) begin
                if (!m_en[p] || m_cnt == 0) begin
                    m_filt[p] = m_s2[p]; m_run[p] = 0;
                end else if (m_s2[p] == m_filt[p]) begin
                    m_run[p] = 0;
                end else if (ms_tick) begin
                    if (m_run[p] + 1 >= int'(m_cnt)) begin
                        m_filt[p] = m_s2[p]; m_run[p] = 0;
                    end else m_run[p]++;
                end
            end
            if (en_we) m_en = en_wdata;
            if (en_mask_we) m_en = (m_en & ~en_mask_wdata[15:8]) | (en_mask_wdata[7:0] & en_mask_wdata[15:8]);
            if (dbc_cnt_we) m_cnt = dbc_cnt_wdata;
        end
        m_s2 = m_s1;
        m_s1 = pin_raw;
        #2;
        if (!rst) begin
            check8(cur_req, "pin_filt", pin_filt, m_filt);
            check8(cur_req, "en_rdata", en_rdata, m_en);
            check8(cur_req, "dbc_cnt_rdata", dbc_cnt_rdata, m_cnt);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
            idle(gap);
        end
    endtask

    task automatic wr_cnt(logic [7:0] v);
        dbc_cnt_we = 1'b1; dbc_cnt_wdata = v; @(negedge clk); dbc_cnt_we = 1'b0;
    endtask

    task automatic wr_en(logic [7:0] v);
        en_we = 1'b1; en_wdata = v; @(negedge clk); en_we = 1'b0;
    endtask

    task automatic wr_mask(logic [7:0] sel, logic [7:0] val);
        en_mask_we = 1'b1; en_mask_wdata = {sel, val}; @(negedge clk); en_mask_we = 1'b0;
    endtask

    initial begin
        rst = 1'b1; pin_raw = 8'hA5; ms_tick = 1'b0;
        en_we = 1'b0; en_wdata = '0; en_mask_we = 1'b0; en_mask_wdata = '0;
        dbc_cnt_we = 1'b0; dbc_cnt_wdata = '0;
        idle(6);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check8("R1", "filt after reset", pin_filt, 8'hA5);
        check8("R1", "enable after reset", en_rdata, 8'h00);
        check8("R1", "count after reset", dbc_cnt_rdata, 8'h00);

        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin pin_raw = 8'($urandom); @(negedge clk); end
        pin_raw = 8'h00; idle(4);

        cur_req = "R3";
        wr_mask(8'h0F, 8'h05); wr_mask(8'hF0, 8'hFF); wr_mask(8'h81, 8'h00);
        check8("R3", "masked enable", en_rdata, 8'h74);

        cur_req = "R4";
        wr_en(8'h3C); wr_cnt(8'd7);
        check8("R4", "direct enable", en_rdata, 8'h3C);
        check8("R4", "count readback", dbc_cnt_rdata, 8'd7);
        en_we = 1'b1; en_wdata = 8'hF0; en_mask_we = 1'b1; en_mask_wdata = {8'h11, 8'h01};
        @(negedge clk); en_we = 1'b0; en_mask_we = 1'b0;
        check8("R4", "same-cycle writes", en_rdata, 8'hE1);

        cur_req = "R5";
        wr_en(8'hFF); wr_cnt(8'd3); idle(2);
        pin_raw = 8'h0F; idle(4);
        ticks(2, 3);
        check8("R5", "held before N ticks", pin_filt, 8'h00);
        ticks(1, 3);
        check8("R5", "changed at N ticks", pin_filt, 8'h0F);

        cur_req = "R6";
        pin_raw = 8'h00; idle(4); ticks(2, 2);
        pin_raw = 8'h0F; idle(4); ticks(1, 2);
        pin_raw = 8'h00; idle(4); ticks(2, 2);
        check8("R6", "bounce restarts", pin_filt, 8'h0F);
        ticks(1, 3);
        check8("R6", "after full run", pin_filt, 8'h00);

        cur_req = "R9";
        pin_raw = 8'hFF; idle(60);
        check8("R9", "no tick no change", pin_filt, 8'h00);

        cur_req = "R8";
        ticks(1, 2);
        wr_mask(8'h02, 8'h00); idle(1);
        check8("R8", "one pin released", pin_filt, 8'h02);
        ticks(2, 3);
        check8("R8", "others keep count", pin_filt, 8'hFF);

        cur_req = "R10";
        wr_en(8'hFF); pin_raw = 8'h00; idle(4);
        wr_cnt(8'd10); ticks(4, 1);
        wr_cnt(8'd2); ticks(1, 3);
        check8("R10", "lowered count", pin_filt, 8'h00);

        cur_req = "R7";
        wr_cnt(8'd0);
        for (int i = 0; i < 30; i++) begin pin_raw = 8'($urandom); @(negedge clk); end
        wr_cnt(8'd255); pin_raw = 8'h5A; idle(4); ticks(20, 0);
        idle(4);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        #3;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule